// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block drives one bank of asynchronous fast-page-mode DRAM on behalf of a cache or CPU port. The DRAM has one shared address bus carrying the row, then the column. The block sequences the row strobe, column strobe, write enable and output enable in whole clock cycles of a nominal 30 ns clock. A request carries a word address split into a row part (upper bits) and a column part (lower bits). It is either a single word or a four-word line. A line covers the aligned group of four columns that holds the requested one: the lowest two column bits advance by one per beat and wrap modulo four, and the upper column bits stay fixed.

After an access the block leaves the row open, so a later request to the same row needs only column strobes. A request to another row first closes the open row and waits out the precharge time. A free-running timer raises a refresh request at a fixed interval, which defaults to about 15.6 µs. The request is served between transfers as a column-before-row refresh that uses the DRAM's internal row counter. An open row is closed and precharged before the refresh. A refresh never breaks into a transfer, and it takes priority over a request that is waiting in the same idle cycle.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and directly after reset, dram_ras_n, dram_cas_n, dram_we_n and dram_oe_n are high, dram_dq_oe is 0 and req_ack is 0.
- R2: When a row is opened, dram_ras_n falls while dram_addr carries the row part (req_addr[19:10]), and the first column strobe falls exactly T_RCD cycles later with the column part (req_addr[9:0]) on dram_addr.
- R3: A line request (req_burst=1) makes exactly four column strobes inside one row opening. Successive strobes are T_CAS+T_CP cycles apart, and beat k uses the column whose lowest two bits are (requested low bits + k) mod 4, with the upper bits unchanged.
- R4: A single-word request (req_burst=0) makes exactly one column strobe.
- R5: A request to the row that is already open opens no row: dram_ras_n stays low and only the column strobe toggles.
- R6: A request to a row other than the open one raises dram_ras_n and holds it high for exactly T_RP cycles before it falls with the new row. No row strobe ever falls after fewer than T_RP high cycles.
- R7: On a write beat, dram_we_n is low and dram_dq_oe is 1 when the column strobe falls, and dram_dq_out carries word k of req_wline (bits k*DATA_W upward) on beat k. On a read beat, dram_oe_n is low, dram_we_n is high and dram_dq_oe is 0.
- R8: Each read beat returns one word on rd_data with rd_valid high for one cycle. Words come back in beat order and equal what was last written to those locations.
- R9: A refresh request is raised every REF_INTERVAL cycles. It is served with the column strobe falling while the row strobe is high and dram_we_n is high. The row strobe then falls, stays low for exactly T_RFSH cycles, and both strobes then stay high for T_RP cycles.
- R10: A refresh starts only between requests, never between req_ack and req_done. It takes priority over a request waiting in the same idle cycle. It starts only after the row strobe has been high for at least T_RP cycles, and each refresh is served before the next one falls due.
- R11: After a refresh no row is open, so the next request opens its row with a new row strobe even when it names the row used last.
- R12: req_ack is high for exactly one cycle for each accepted request, and req_done is high for exactly one cycle once the last beat's column strobe has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word line, 0 = single word |
| req_addr | input | ROW_W+COL_W | Word address, row part in the upper bits |
| req_wline | input | BURST_LEN*DATA_W | Write data; word k in bits k*DATA_W upward |
| req_ack | output | 1 | Request accepted this cycle |
| req_done | output | 1 | Last beat of the current request finished |
| rd_valid | output | 1 | rd_data holds a read word |
| rd_data | output | DATA_W | Read word |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The case that needs care is a refresh falling due in the same idle cycle in which a request is waiting. To provoke it, the bench issues line reads and writes back to back across a few rows with a short refresh interval, so a request is nearly always pending when the timer fires. It judges the result at the DRAM pins. No column-before-row refresh may start inside an ack-to-done window. Every refresh must follow at least T_RP cycles of row-strobe high. The refresh count must keep pace with the elapsed time. The scoreboard must still see every read word correct and in order after the delayed request finally opens its row.

// File: rtl/fpm_pkg.sv
// Package: shared types for the fast-page-mode DRAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fpm_pkg;

    // Sequencer states: access path first, refresh path last.
    typedef enum logic [3:0] {
        ST_IDLE,   // row may be open, waiting for work
        ST_PRE,    // row strobe high, precharge count
        ST_ACT,    // row strobe low, row-to-column count
        ST_CSET,   // column address setup before a page-hit strobe
        ST_CLO,    // column strobe low
        ST_CHI,    // column strobe high between beats
        ST_RCAS,   // refresh: column strobe low ahead of row strobe
        ST_RRAS,   // refresh: both strobes low
        ST_RPRE    // refresh: precharge after refresh
    } seq_state_e;

    // Larger of two integers, used to size counters.
    function automatic int fpm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_refresh_timer.sv
// Module: fpm_refresh_timer
// Free-running interval counter that raises a refresh request every
// REF_INTERVAL cycles and holds it until the sequencer grants it.
// Assumes: the sequencer grants well within one interval.
module fpm_refresh_timer #(
    parameter int REF_INTERVAL = 520
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_grant,
    output logic ref_pend
);
    localparam int TW = $clog2(REF_INTERVAL + 1);
    localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] tmr_q;
    logic          tick;
    logic          pend_q;

    assign tick     = (tmr_q == LAST);
    assign ref_pend = pend_q;

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr_q <= '0;
        else if (tick) tmr_q <= '0;
        else           tmr_q <= tmr_q + 1'b1;
    end

    // Hold a pending refresh from the interval tick until granted.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (tick)      pend_q <= 1'b1;
        else if (ref_grant) pend_q <= 1'b0;
    end

    AST_REF_NOT_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !pend_q);  // R10
    AST_GRANT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> pend_q);  // R9

endmodule

// File: rtl/fpm_page_tracker.sv
// Module: fpm_page_tracker
// Remembers which row is open in the bank and flags a page hit when the
// incoming row matches it.
// Assumes: open and close are never requested in the same cycle.
module fpm_page_tracker #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic             row_hit
);
    logic [ROW_W-1:0] row_q;
    logic             open_q;

    // Record the row on opening; forget it on closing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_req) begin
            open_q <= 1'b1;
            row_q  <= open_row;
        end else if (close_req) begin
            open_q <= 1'b0;
        end
    end

    assign row_open = open_q;
    assign row_hit  = open_q && (row_q == cmp_row);

    AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_req && close_req));  // R6

endmodule

// File: rtl/fpm_addr_mux.sv
// Module: fpm_addr_mux
// Selects the row or the column part onto the shared DRAM address pins,
// zero-extending the narrower part.
// Assumes: OUT_W is at least as wide as both parts.
module fpm_addr_mux #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int OUT_W = 10
) (
    input  logic             sel_row,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [OUT_W-1:0] addr
);
    // Steer one address half onto the pins.
    always_comb begin
        if (sel_row) addr = OUT_W'(row);
        else         addr = OUT_W'(col);
    end

endmodule

// File: rtl/fpm_seq.sv
// Module: fpm_seq
// Strobe sequencer: accepts requests, opens/closes rows, issues column
// beats in page mode, returns read words and runs refresh sequences.
// Assumes: all timing counts are at least 1; BURST_LEN is a power of two >= 2.
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 1,
    parameter int T_CP      = 1,
    parameter int T_RP      = 2,
    parameter int T_RFSH    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic                        req_burst,
    input  logic [ROW_W-1:0]            req_row,
    input  logic [COL_W-1:0]            req_col,
    input  logic [BURST_LEN*DATA_W-1:0] req_wline,
    input  logic                        row_open,
    input  logic                        row_hit,
    input  logic                        ref_pend,
    input  logic [DATA_W-1:0]           dq_in,
    output logic                        req_ack,
    output logic                        req_done,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        ref_grant,
    output logic                        trk_open,
    output logic                        trk_close,
    output logic [ROW_W-1:0]            open_row,
    output logic                        sel_row,
    output logic [ROW_W-1:0]            cur_row,
    output logic [COL_W-1:0]            cur_col,
    output logic                        ras_n,
    output logic                        cas_n,
    output logic                        we_n,
    output logic                        oe_n,
    output logic [DATA_W-1:0]           dq_out,
    output logic                        dq_oe
);
    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam int MAXT   = fpm_max(fpm_max(fpm_max(T_RCD, T_CAS),
                                            fpm_max(T_CP, T_RP)), T_RFSH);
    localparam int CNT_W  = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_CAS  = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] L_CP   = CNT_W'(T_CP - 1);
    localparam logic [CNT_W-1:0] L_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] L_RFSH = CNT_W'(T_RFSH - 1);
    localparam logic [BEAT_W:0]  N_LINE = (BEAT_W+1)'(BURST_LEN);
    localparam int SAT_W  = CNT_W + 1;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BEAT_W:0]   beat_q, beat_d;
    logic              wr_q, burst_q, to_ref_q, to_ref_d;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] line_q [BURST_LEN];
    logic              load;
    logic [BEAT_W:0]   n_beats;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              in_body;

    assign n_beats = burst_q ? N_LINE : (BEAT_W+1)'(1);

    // Next-state, acceptance and tracker commands.
    always_comb begin
        state_d   = state_q;
        beat_d    = beat_q;
        to_ref_d  = to_ref_q;
        load      = 1'b0;
        req_ack   = 1'b0;
        req_done  = 1'b0;
        ref_grant = 1'b0;
        trk_open  = 1'b0;
        trk_close = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_grant = 1'b1;
                    if (row_open) begin
                        trk_close = 1'b1;
                        to_ref_d  = 1'b1;
                        state_d   = ST_PRE;
                    end else begin
                        state_d = ST_RCAS;
                    end
                end else if (req_valid) begin
                    req_ack = 1'b1;
                    load    = 1'b1;
                    beat_d  = '0;
                    if (row_hit) begin
                        state_d = ST_CSET;
                    end else if (row_open) begin
                        trk_close = 1'b1;
                        to_ref_d  = 1'b0;
                        state_d   = ST_PRE;
                    end else begin
                        trk_open = 1'b1;
                        state_d  = ST_ACT;
                    end
                end
            end
            ST_PRE: begin
                if (cnt_q == L_RP) begin
                    if (to_ref_q) begin
                        state_d = ST_RCAS;
                    end else begin
                        trk_open = 1'b1;
                        state_d  = ST_ACT;
                    end
                end
            end
            ST_ACT:  if (cnt_q == L_RCD) state_d = ST_CLO;
            ST_CSET: state_d = ST_CLO;
            ST_CLO: begin
                if (cnt_q == L_CAS) begin
                    beat_d  = beat_q + 1'b1;
                    state_d = ST_CHI;
                end
            end
            ST_CHI: begin
                if (cnt_q == L_CP) begin
                    if (beat_q == n_beats) begin
                        req_done = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        state_d = ST_CLO;
                    end
                end
            end
            ST_RCAS: state_d = ST_RRAS;
            ST_RRAS: if (cnt_q == L_RFSH) state_d = ST_RPRE;
            ST_RPRE: if (cnt_q == L_RP) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, phase counter and beat index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            beat_q   <= '0;
            to_ref_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            beat_q   <= beat_d;
            to_ref_q <= to_ref_d;
        end
    end

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            burst_q <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else if (load) begin
            wr_q    <= req_write;
            burst_q <= req_burst;
            row_q   <= req_row;
            col_q   <= req_col;
        end
    end

    // Latch the write line word by word.
    for (genvar w = 0; w < BURST_LEN; w++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)    line_q[w] <= '0;
            else if (load) line_q[w] <= req_wline[w*DATA_W +: DATA_W];
        end
    end

    // Capture the read word at the end of each read column pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= (state_q == ST_CLO) && (cnt_q == L_CAS) && !wr_q;
            if ((state_q == ST_CLO) && (cnt_q == L_CAS) && !wr_q)
                rd_data_q <= dq_in;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // Row to record: the incoming row from idle, else the latched one.
    assign open_row = (state_q == ST_IDLE) ? req_row : row_q;
    assign cur_row  = row_q;
    assign cur_col  = {col_q[COL_W-1:BEAT_W], col_q[BEAT_W-1:0] + beat_q[BEAT_W-1:0]};
    assign sel_row  = (state_q == ST_ACT) && (cnt_q == '0);
    assign in_body  = (state_q == ST_ACT) || (state_q == ST_CSET) ||
                      (state_q == ST_CLO) || (state_q == ST_CHI);

    // Decode the DRAM strobes from the sequencer state.
    always_comb begin
        ras_n  = !(in_body || (state_q == ST_RRAS) ||
                   ((state_q == ST_IDLE) && row_open));
        cas_n  = !((state_q == ST_CLO) || (state_q == ST_RCAS) ||
                   (state_q == ST_RRAS));
        we_n   = !(wr_q && in_body);
        oe_n   = !(!wr_q && (state_q == ST_CLO));
        dq_oe  = wr_q && in_body;
        dq_out = line_q[beat_q[BEAT_W-1:0]];
    end

    // Checker-side counts of how long each strobe level has lasted.
    logic [SAT_W-1:0] ras_hi_cnt, ras_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_hi_cnt <= SAT_W'(T_RP);
            ras_lo_cnt <= '0;
        end else begin
            if (!ras_n)                       ras_hi_cnt <= '0;
            else if (ras_hi_cnt != '1)        ras_hi_cnt <= ras_hi_cnt + 1'b1;
            if (ras_n)                        ras_lo_cnt <= '0;
            else if (ras_lo_cnt != '1)        ras_lo_cnt <= ras_lo_cnt + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ras_n && cas_n && we_n && oe_n && !dq_oe));  // R1
    AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> (ras_lo_cnt >= SAT_W'(T_RCD)));  // R2
    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_cnt >= SAT_W'(T_RP)));  // R6
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> ($past(!cas_n) && we_n));  // R9
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);  // R12
    AST_REF_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !ref_pend);  // R10

endmodule

// File: rtl/fpm_dram_ctrl.sv
// Module: fpm_dram_ctrl (top)
// Fast-page-mode DRAM controller: request port on one side, multiplexed
// asynchronous DRAM pins on the other, with open-row reuse and periodic
// column-before-row refresh.
// Assumes: one bank; timing counts are in controller clock cycles.
module fpm_dram_ctrl #(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 16,
    parameter int BURST_LEN    = 4,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 1,
    parameter int T_CP         = 1,
    parameter int T_RP         = 2,
    parameter int T_RFSH       = 3,
    parameter int REF_INTERVAL = 520,
    localparam int AW          = ROW_W + COL_W,
    localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic                        req_burst,
    input  logic [AW-1:0]               req_addr,
    input  logic [BURST_LEN*DATA_W-1:0] req_wline,
    output logic                        req_ack,
    output logic                        req_done,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic [MUX_W-1:0]            dram_addr,
    output logic                        dram_ras_n,
    output logic                        dram_cas_n,
    output logic                        dram_we_n,
    output logic                        dram_oe_n,
    output logic [DATA_W-1:0]           dram_dq_out,
    output logic                        dram_dq_oe,
    input  logic [DATA_W-1:0]           dram_dq_in
);
    logic             ref_pend, ref_grant;
    logic             trk_open, trk_close, row_open, row_hit;
    logic [ROW_W-1:0] open_row, cur_row, req_row;
    logic [COL_W-1:0] cur_col, req_col;
    logic             sel_row;

    assign req_row = req_addr[AW-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    fpm_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) i_timer (
        .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_pend(ref_pend)
    );

    fpm_page_tracker #(.ROW_W(ROW_W)) i_tracker (
        .clk(clk), .rst_n(rst_n), .open_req(trk_open), .close_req(trk_close),
        .open_row(open_row), .cmp_row(req_row),
        .row_open(row_open), .row_hit(row_hit)
    );

    fpm_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RFSH(T_RFSH)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_row(req_row), .req_col(req_col), .req_wline(req_wline),
        .row_open(row_open), .row_hit(row_hit), .ref_pend(ref_pend),
        .dq_in(dram_dq_in),
        .req_ack(req_ack), .req_done(req_done),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_grant(ref_grant), .trk_open(trk_open), .trk_close(trk_close),
        .open_row(open_row), .sel_row(sel_row),
        .cur_row(cur_row), .cur_col(cur_col),
        .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
        .oe_n(dram_oe_n), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe)
    );

    fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .OUT_W(MUX_W)) i_mux (
        .sel_row(sel_row), .row(cur_row), .col(cur_col), .addr(dram_addr)
    );

endmodule

// File: tb/test_fpm_dram_ctrl.sv
// Bench: scoreboard check of fpm_dram_ctrl against a simple DRAM model.
module test_fpm_dram_ctrl;
    localparam int DW = 16, RW = 10, CW = 10, BL = 4;
    localparam int T_RCD = 2, T_CAS = 1, T_CP = 1, T_RP = 2, T_RFSH = 3;
    localparam int RI = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_burst = 0;
    logic [RW+CW-1:0] req_addr = '0;
    logic [BL*DW-1:0] req_wline = '0;
    logic req_ack, req_done, rd_valid;
    logic [DW-1:0] rd_data, dram_dq_out, dram_dq_in;
    logic [9:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

    always #4 clk = ~clk;

    fpm_dram_ctrl #(.REF_INTERVAL(RI)) i_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_burst(req_burst), .req_addr(req_addr), .req_wline(req_wline),
        .req_ack(req_ack), .req_done(req_done), .rd_valid(rd_valid),
        .rd_data(rd_data), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // DRAM model: latch row on row-strobe fall, access on column-strobe fall.
    logic [DW-1:0] mem [int unsigned];
    logic [9:0] m_row = '0;
    logic [DW-1:0] m_rd = '0;
    always @(negedge dram_ras_n) begin
        #1;
        if (dram_cas_n) m_row = dram_addr;
    end
    always @(negedge dram_cas_n) begin
        #1;
        if (!dram_ras_n) begin
            if (!dram_we_n) mem[{m_row, dram_addr}] = dram_dq_out;
            else if (mem.exists({m_row, dram_addr})) m_rd = mem[{m_row, dram_addr}];
            else m_rd = 16'hdead;
        end
    end
    assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? m_rd : '0;

    // Pin monitor state.
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    logic prev_ras = 1, prev_cas = 1;
    int ras_hi_run = 100, ref_lo_run = 0, last_pre = 0;
    int opens = 0, refs = 0, beats = 0, beat_idx = 0, dones = 0, acks = 0;
    bit in_ref = 0, first_cas = 0, busy = 0, writing = 0;
    longint open_cyc = 0, cas_cyc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                if (!dram_cas_n) begin
                    refs++; in_ref = 1; ref_lo_run = 0;
                end else begin
                    opens++; open_cyc = cyc; first_cas = 1; last_pre = ras_hi_run;
                    chk(ras_hi_run >= T_RP, "R6 precharge before open", ras_hi_run, T_RP);
                end
            end
            if (prev_cas && !dram_cas_n) begin
                if (dram_ras_n) begin
                    chk(dram_we_n, "R9 we high in refresh", dram_we_n, 1);
                    chk(ras_hi_run >= T_RP, "R10 precharge before refresh", ras_hi_run, T_RP);
                    chk(!busy, "R10 refresh inside request", busy, 0);
                end else begin
                    beats++;
                    if (first_cas) chk(cyc - open_cyc == T_RCD, "R2 row to column", cyc - open_cyc, T_RCD);
                    first_cas = 0;
                    if (beat_idx > 0) chk(cyc - cas_cyc == T_CAS + T_CP, "R3 beat spacing", cyc - cas_cyc, T_CAS + T_CP);
                    beat_idx++; cas_cyc = cyc;
                    if (writing) chk(!dram_we_n && dram_dq_oe, "R7 write beat", {dram_we_n, dram_dq_oe}, 1);
                    else chk(dram_we_n && !dram_oe_n && !dram_dq_oe, "R7 read beat", {dram_we_n, dram_oe_n, dram_dq_oe}, 4);
                end
            end
            if (!prev_ras && dram_ras_n && in_ref) begin
                chk(ref_lo_run == T_RFSH, "R9 refresh low time", ref_lo_run, T_RFSH);
                in_ref = 0;
            end
            if (dram_ras_n) ras_hi_run++; else ras_hi_run = 0;
            if (!dram_ras_n && in_ref) ref_lo_run++;
            if (req_done) dones++;
            prev_ras = dram_ras_n; prev_cas = dram_cas_n;
        end
    end

    // Scoreboard: expected read words queued by the driver, popped here.
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] shadow [int unsigned];
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R8 unexpected read word", rd_data, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R8 read data", rd_data, e);
            end
        end
    end

    function automatic int unsigned beat_key(int row, int col, int k);
        int c;
        c = (col & ~3) | ((col + k) & 3);
        return (row << CW) | c;
    endfunction

    // Driver: issue one request, keep the scoreboard and beat count.
    task automatic issue(input bit wr, input bit bu, input int row, input int col, input int seed);
        int n, b0;
        n = bu ? 4 : 1;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_burst = bu;
        req_addr = (RW+CW)'((row << CW) | col);
        for (int k = 0; k < BL; k++) req_wline[k*DW +: DW] = DW'(seed * 97 + k * 13 + row);
        #1;
        while (!req_ack) begin @(negedge clk); #1; end
        acks++; busy = 1; beat_idx = 0; writing = wr; b0 = beats;
        for (int k = 0; k < n; k++) begin
            if (wr) shadow[beat_key(row, col, k)] = req_wline[k*DW +: DW];
            else exp_q.push_back(shadow.exists(beat_key(row, col, k)) ?
                                 shadow[beat_key(row, col, k)] : 16'hdead);
        end
        @(negedge clk);
        req_valid = 0;
        while (!req_done) @(negedge clk);
        busy = 0;
        chk(beats - b0 == n, bu ? "R3 four beats" : "R4 one beat", beats - b0, n);
    endtask

    initial begin
        int o0, r0;
        longint c0;
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !req_ack,
            "R1 reset pins", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe}, 30);
        rst_n = 1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && !req_ack, "R1 after reset", {dram_ras_n, dram_cas_n}, 3);

        // Line write from a closed bank, starting mid-line to test the wrap.
        o0 = opens;
        issue(1, 1, 5, 6, 1);
        chk(opens - o0 == 1, "R2 one row opened", opens - o0, 1);
        // Single reads in the open row: page hits, each column checked.
        o0 = opens;
        for (int c = 4; c < 8; c++) issue(0, 0, 5, c, 0);
        chk(opens == o0, "R5 no row strobe on page hit", opens - o0, 0);
        issue(0, 1, 5, 4, 0);
        chk(opens == o0, "R5 line read page hit", opens - o0, 0);

        // Page miss.
        issue(1, 0, 9, 100, 2);
        chk(opens - o0 == 1, "R6 page miss opens row", opens - o0, 1);
        chk(last_pre == T_RP, "R6 exact precharge", last_pre, T_RP);
        issue(0, 0, 9, 100, 0);

        // Idle refresh cadence.
        r0 = refs;
        repeat (RI * 8) @(negedge clk);
        chk(refs - r0 >= 7 && refs - r0 <= 9, "R9 refresh count", refs - r0, 8);
        chk(dram_ras_n, "R11 row closed after refresh", dram_ras_n, 1);
        o0 = opens;
        issue(0, 0, 9, 100, 0);
        chk(opens - o0 == 1, "R11 reopen same row", opens - o0, 1);

        // Saturating traffic: refresh ticks meet waiting requests.
        r0 = refs; c0 = cyc;
        for (int i = 0; i < 60; i++) begin
            int row, col;
            row = ((i / 4) % 3) * 7 + 2;
            col = ((i / 2) * 12) % 1024;
            issue(!(i % 2), 1, row, col, i / 2 + 10);
        end
        chk(refs - r0 + 1 >= int'((cyc - c0) / RI), "R10 refresh keeps pace", refs - r0, (cyc - c0) / RI);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
        chk(dones == acks, "R12 done per ack", dones, acks);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule